// File: doc/BRIEF.md
# Rotating-Priority Interrupt Vector Arbiter

Four serial channels each raise interrupts from four independently enabled sources (transmit, receive, line status, modem status). This block merges them onto one shared active-low request line. When the host runs an interrupt-select cycle, the block picks the pending channel with the highest current priority. It returns that channel's 8-bit vector, which the channel keeps in its own scratchpad register. Then it rotates priority so that the channel just served drops to lowest.

The select cycle is a valid/ready exchange. The host raises `sel_valid` and holds it high until it sees `sel_ready`. The winner and its vector are captured on the first clock edge that sees `sel_valid`. The block then inserts two wait cycles and raises `sel_ready` for exactly one cycle. During that cycle `vec_out` and `served` are valid. Back-pressure is on the block's side only: the host may not withdraw or change the request before `sel_ready`. After the acknowledge, the host drops `sel_valid` or starts a fresh cycle. A fresh cycle is captured one cycle after the acknowledge.

Top module: `irq_rotor`

## Requirements
- R1: `irq_n` is low whenever at least one channel has a pending enabled source, and high otherwise. It changes in the same cycle as its inputs, with no clock delay.
- R2: Channel c is pending when `src_pend[4c+s] & src_en[4c+s]` holds for some source s (s=0 transmit, 1 receive, 2 line status, 3 modem status). A pending source whose enable bit is 0 has no effect.
- R3: After reset, channel 0 (A) has the highest priority, followed by 1 (B), 2 (C) and 3 (D).
- R4: After channel k is served, the order becomes k+1, k+2, … (modulo 4), with k last.
- R5: A select cycle returns the vector of the winning channel, `vec_in[8c+7:8c]`, as it stood on the capture edge.
- R6: The capture edge is followed by two wait cycles. `sel_ready` is then high for exactly one cycle: it is first seen three clock edges after `sel_valid` is first sampled.
- R7: The winner, its vector and the served indication do not change between capture and acknowledge, even if requests or vectors change meanwhile.
- R8: `served` is one-hot for the winning channel (bit c = channel c) during the acknowledge cycle, and all-zero in every other cycle.
- R9: A select cycle captured with nothing pending returns 0x00 and `served` = 0, and leaves priority unchanged.
- R10: Priority changes only when a select cycle that served a channel completes. Request activity alone never moves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | 16 | Per-source pending flags, 4 per channel (bit 4c+s) |
| src_en | input | 16 | Per-source enables, same layout as `src_pend` |
| vec_in | input | 32 | Scratchpad vector of each channel, 8 bits each (bits 8c+7:8c) |
| sel_valid | input | 1 | Host interrupt-select request, held until `sel_ready` |
| sel_ready | output | 1 | Acknowledge, one cycle, after the wait states |
| vec_out | output | 8 | Vector of the served channel, valid with `sel_ready` |
| served | output | 4 | One-hot served channel during the acknowledge cycle |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
The rotation is tried with every channel pending, which walks the pointer through all four positions and back to A. It is also tried with sparse patterns (A and C; B and D), which separate a true rotating search from a fixed order or a plain round-robin step. An empty select followed by a sparse one shows whether a cycle with nothing pending moves the pointer. Changing requests and vectors during the wait cycles tells a captured winner from a live one. Source patterns with and without enables separate the per-source masking from the raw flags.

// File: rtl/irq_rotor_pkg.sv
package irq_rotor_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_WAIT = 2'd1,
    SEL_ACK  = 2'd2
  } sel_state_e;
endpackage

// File: rtl/irq_pend_merge.sv
// Folds each channel's enabled interrupt sources into one pending flag.
module irq_pend_merge #(
  parameter int NCH  = 4,
  parameter int NSRC = 4
) (
  input  logic [NCH*NSRC-1:0] src_pend,
  input  logic [NCH*NSRC-1:0] src_en,
  output logic [NCH-1:0]      ch_pend
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_pend[c] = |(src_pend[c*NSRC +: NSRC] & src_en[c*NSRC +: NSRC]);
  end
endmodule

// File: rtl/irq_rr_pick.sv
// Finds the first pending channel, searching upward from the head pointer.
module irq_rr_pick #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0] ch_pend,
  input  logic [IW-1:0]  head,
  output logic           any,
  output logic [IW-1:0]  win
);
  always_comb begin
    logic found;
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < NCH; i++) begin
      int unsigned j;
      j = (int'(head) + i) % NCH;
      if (!found && ch_pend[j]) begin
        found = 1'b1;
        win   = IW'(j);
      end
    end
    any = |ch_pend;
  end
endmodule

// File: rtl/irq_sel_fsm.sv
// Select-cycle sequencer: captures the winner, inserts wait states, acknowledges.
module irq_sel_fsm
  import irq_rotor_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int VW    = 8,
  parameter int IW    = 2,
  parameter int WAITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  logic              any,
  input  logic [IW-1:0]     win,
  input  logic [NCH*VW-1:0] vec_all,
  output logic              sel_ready,
  output logic [VW-1:0]     vec_out,
  output logic [NCH-1:0]    served,
  output logic              done_hit,
  output logic [IW-1:0]     done_idx
);
  localparam int CW = (WAITS > 1) ? $clog2(WAITS) : 1;

  sel_state_e      state;
  logic [CW-1:0]   cnt;
  logic [VW-1:0]   vec_q;
  logic [IW-1:0]   win_q;
  logic            hit_q;
  logic [VW-1:0]   vec_pick;

  always_comb begin
    vec_pick = '0;
    for (int c = 0; c < NCH; c++)
      if (win == IW'(c)) vec_pick = vec_all[c*VW +: VW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEL_IDLE;
      cnt   <= '0;
      vec_q <= '0;
      win_q <= '0;
      hit_q <= 1'b0;
    end else begin
      unique case (state)
        SEL_IDLE: if (sel_valid) begin
          state <= SEL_WAIT;
          cnt   <= '0;
          hit_q <= any;
          win_q <= win;
          vec_q <= any ? vec_pick : '0;
        end
        SEL_WAIT: begin
          if (cnt == CW'(WAITS-1)) state <= SEL_ACK;
          else                     cnt   <= cnt + 1'b1;
        end
        SEL_ACK:  state <= SEL_IDLE;
        default:  state <= SEL_IDLE;
      endcase
    end
  end

  assign sel_ready = (state == SEL_ACK);
  assign vec_out   = vec_q;
  assign done_hit  = sel_ready & hit_q;
  assign done_idx  = win_q;

  for (genvar c = 0; c < NCH; c++) begin : g_srv
    assign served[c] = done_hit & (win_q == IW'(c));
  end

  // R6: acknowledge lasts a single cycle and follows a wait cycle
  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ready |=> !sel_ready);
  p_ack_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ready |-> $past(state) == SEL_WAIT);
  // R7: captured result is frozen through the wait states
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEL_WAIT) |=> ($stable(vec_q) && $stable(win_q) && $stable(hit_q)));
  // R8: at most one channel reported served
  p_served_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(served));
  // R9: empty select yields a zero vector
  p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ready && served == '0) |-> vec_out == '0);
endmodule

// File: rtl/irq_rotor.sv
module irq_rotor #(
  parameter int NCH   = 4,
  parameter int NSRC  = 4,
  parameter int VW    = 8,
  parameter int WAITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH*NSRC-1:0] src_pend,
  input  logic [NCH*NSRC-1:0] src_en,
  input  logic [NCH*VW-1:0]   vec_in,
  input  logic                sel_valid,
  output logic                sel_ready,
  output logic [VW-1:0]       vec_out,
  output logic [NCH-1:0]      served,
  output logic                irq_n
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] ch_pend;
  logic [IW-1:0]  head;
  logic           any;
  logic [IW-1:0]  win;
  logic           done_hit;
  logic [IW-1:0]  done_idx;

  irq_pend_merge #(.NCH(NCH), .NSRC(NSRC)) u_merge (
    .src_pend (src_pend),
    .src_en   (src_en),
    .ch_pend  (ch_pend)
  );

  irq_rr_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .ch_pend (ch_pend),
    .head    (head),
    .any     (any),
    .win     (win)
  );

  irq_sel_fsm #(.NCH(NCH), .VW(VW), .IW(IW), .WAITS(WAITS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_valid (sel_valid),
    .any       (any),
    .win       (win),
    .vec_all   (vec_in),
    .sel_ready (sel_ready),
    .vec_out   (vec_out),
    .served    (served),
    .done_hit  (done_hit),
    .done_idx  (done_idx)
  );

  // Head pointer: the channel after the one last served ranks first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        head <= '0;
    else if (done_hit) head <= (done_idx == IW'(NCH-1)) ? '0 : done_idx + 1'b1;
  end

  assign irq_n = ~any;

  // R1: request line mirrors enabled pending sources
  p_irq_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ((src_pend & src_en) == '0));
  // R10: head moves only when a channel is actually served
  p_head_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_ready && served != '0) |=> $stable(head));
  // R4: the served channel ends up ranked last, so it cannot be next head
  p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> head != $past(done_idx));
endmodule

// File: tb/irq_rotor_test.sv
module irq_rotor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_pend = '0;
  logic [15:0] src_en = '0;
  logic [31:0] vec_in = '0;
  logic        sel_valid = 1'b0;
  logic        sel_ready;
  logic [7:0]  vec_out;
  logic [3:0]  served;
  logic        irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  int model_head = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  irq_rotor uut (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
    .vec_in(vec_in), .sel_valid(sel_valid), .sel_ready(sel_ready),
    .vec_out(vec_out), .served(served), .irq_n(irq_n)
  );

  function automatic logic [3:0] ch_model(input logic [15:0] p, input logic [15:0] e);
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = |(p[c*4 +: 4] & e[c*4 +: 4]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: predicts the result, queues it, then runs one select cycle.
  task automatic do_select(input string tag, input bit perturb);
    logic [3:0] pd;
    logic [3:0] oh;
    logic [7:0] v;
    int w;
    int n;
    pd = ch_model(src_pend, src_en);
    w = -1;
    for (int i = 0; i < 4; i++) begin
      int j;
      j = (model_head + i) % 4;
      if (w < 0 && pd[j]) w = j;
    end
    if (w >= 0) begin
      oh = 4'b0001 << w;
      v  = vec_in[w*8 +: 8];
      model_head = (w + 1) % 4;
    end else begin
      oh = '0;
      v  = 8'h00;
    end
    exp_q.push_back({oh, v});
    tag_q.push_back(tag);
    sel_valid = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (perturb && n == 1) begin
        src_pend = 16'hFFFF;
        src_en   = 16'hFFFF;
        vec_in   = 32'hEEEE_EEEE;
      end
      if (sel_ready || n > 10) break;
    end
    check({tag, " R6 ack latency"}, n, 3);
    sel_valid = 1'b0;
    @(negedge clk);
    check({tag, " R6 single-cycle ack"}, sel_ready, 1'b0);
  endtask

  // Monitor: compares each acknowledge against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && sel_ready) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected ack", 1, 0);
        end else begin
          logic [11:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " R5 vector"}, vec_out, e[7:0]);
          check({t, " R8 served"}, served, e[11:8]);
        end
      end else if (rst_n && served !== 4'b0000) begin
        check("R8 served outside ack", served, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset irq_n", irq_n, 1'b1);
    check("R3 reset ready", sel_ready, 1'b0);
    check("R8 reset served", served, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: a pending but disabled source is ignored
    src_pend = 16'h0200;
    src_en   = 16'h0100;
    #1 check("R2 disabled source", irq_n, 1'b1);
    src_en = 16'h0200;
    #1 check("R1 enabled source", irq_n, 1'b0);
    src_pend = 16'h0;
    #1 check("R1 no source", irq_n, 1'b1);
    @(negedge clk);

    // R3 / R4: all pending walks A,B,C,D,A
    vec_in   = 32'h4433_2211;
    src_en   = 16'hFFFF;
    src_pend = 16'h1111;
    #1 check("R1 all pending", irq_n, 1'b0);
    do_select("R3 first A", 0);
    do_select("R4 then B", 0);
    do_select("R4 then C", 0);
    do_select("R4 then D", 0);
    do_select("R4 wrap A", 0);

    // R4: sparse A and C from head B
    src_pend = 16'h0101;
    do_select("R4 sparse C", 0);
    do_select("R4 sparse A", 0);

    // R9: empty select keeps head at B
    src_pend = 16'h0000;
    #1 check("R1 idle line", irq_n, 1'b1);
    do_select("R9 empty", 0);
    src_pend = 16'h8020;
    do_select("R9 head kept B", 0);

    // R7: D captured, then everything changes during the wait states
    src_pend = 16'h4000;
    do_select("R7 frozen D", 1);
    vec_in   = 32'h4433_2211;
    src_pend = 16'h0;

    // R10: request activity alone leaves head at A
    for (int k = 0; k < 6; k++) begin
      src_pend = (k % 2 == 0) ? 16'h0880 : 16'h0000;
      @(negedge clk);
    end
    vec_in[7:0] = 8'h5A;
    src_pend = 16'h1111;
    do_select("R10 head still A R5 new vec", 0);

    repeat (4) @(negedge clk);
    check("R5 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule